// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This unit sits beside a cluster of harts and gives each of them two interrupt sources. It holds a software-interrupt flag per hart, which any hart can set or clear through a register store to raise an inter-processor interrupt. It also holds a 64-bit deadline per hart, compared without pause against one shared 64-bit time counter. The counter advances by one on every cycle in which the tick enable is high.

Software reaches all of this over a plain 32-bit register port. A read request returns its data one cycle later. The register layout is sparse and fixed. Flag words start at 0x0000 with a stride of 4 bytes per hart. Deadline pairs start at 0x4000 with a stride of 8 bytes per hart. The counter pair sits at 0xBFF8. Every 64-bit quantity is split into a low word at its base and a high word at base+4. To arm a one-shot event, software reads the counter, adds its delay, and stores the sum as the hart's deadline. A 32-bit host reads the counter by reading high, then low, then high again, and retries when the two high reads differ.

Top module: `hart_timer_unit`

## Requirements
- R1: After reset every software flag, every timer interrupt and the counter are zero, and each deadline reads back as all ones.
- R2: A store to the word at 4*h sets hart h's software interrupt to bit 0 of the data (1 raises it, 0 clears it). Reading that word returns the flag in bit 0, with bits 31:1 as zero. The flags change only on such stores.
- R3: A hart's deadline low word sits at 0x4000+8*h and its high word at 0x4004+8*h. Both can be written and read back independently.
- R4: The counter words at 0xBFF8 (low) and 0xBFFC (high) go up by exactly one in each cycle where tick_i is high, and they hold in every other cycle.
- R5: A counter increment carries from the low word into the high word, and the counter wraps from all ones to zero only at the full 64-bit width.
- R6: A store to either counter word in a cycle where tick_i is high loads the written word and suppresses that cycle's increment. The other word is left unchanged.
- R7: tmr_irq_o[h] is high while the counter is greater than or equal to hart h's deadline. The line holds as time passes and drops only when a larger deadline is written.
- R8: Any offset that is not word aligned, that falls outside the three regions, or that names a hart at or beyond NUM_HARTS reads as zero, and stores to it change no state.
- R9: bus_rvalid_o is high exactly in the cycle after a read request and in no other cycle. The data it carries is the register value as it stood in the request cycle.
- R10: With the counter ticking on every cycle, a high-low-high read sequence in which both high reads agree gives a coherent 64-bit value. This holds even when the low word carries over during a failed attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = store, 0 = load |
| bus_addr_i | input | 16 | Byte offset |
| bus_wdata_i | input | 32 | Store data |
| bus_rvalid_o | output | 1 | Load response valid, one cycle after the request |
| bus_rdata_o | output | 32 | Load response data |
| tick_i | input | 1 | Counter advance enable |
| sw_irq_o | output | NUM_HARTS | Software interrupt, one per hart |
| tmr_irq_o | output | NUM_HARTS | Timer interrupt, one per hart |

## Verification
A store to a counter word and a tick can land in the same cycle. The bench drives both on one clock edge and then reads both words back. It expects the written word exactly and the other word unchanged, with no trace of the increment. A load can also land in the cycle where the low word carries into the high word. The bench runs the counter through that boundary during a high-low-high sequence and expects the first attempt to disagree and the retry to return the exact value predicted for that cycle.

// File: rtl/htu_pkg.sv
package htu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 64;
  localparam logic [15:0] CMP_BASE  = 16'h4000;
  localparam logic [15:0] TIME_BASE = 16'hBFF8;
  typedef logic [TIME_W-1:0] time_t;
endpackage

// File: rtl/htu_decode.sv
module htu_decode #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic [15:0]          addr_i,
  output logic [NUM_HARTS-1:0] sel_sw_o,
  output logic [NUM_HARTS-1:0] sel_cmp_o,
  output logic                 sel_tim_o,
  output logic                 hi_o
);
  import htu_pkg::*;

  logic        aligned;
  logic        in_sw;
  logic        in_cmp;
  logic [12:0] cmp_slot;

  assign aligned   = addr_i[1:0] == 2'b00;
  assign in_sw     = aligned && (addr_i < CMP_BASE);
  assign in_cmp    = aligned && (addr_i >= CMP_BASE) && (addr_i < TIME_BASE);
  assign sel_tim_o = aligned && (addr_i[15:3] == TIME_BASE[15:3]);
  assign cmp_slot  = addr_i[15:3] - CMP_BASE[15:3];
  assign hi_o      = addr_i[2];

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
    assign sel_sw_o[h]  = in_sw  && (addr_i[13:2] == 12'(h));
    assign sel_cmp_o[h] = in_cmp && (cmp_slot == 13'(h));
  end
endmodule

// File: rtl/htu_mtime.sv
module htu_mtime (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [31:0]   wdata_i,
  output htu_pkg::time_t mtime_o
);
  htu_pkg::time_t cnt_q;

  // a store wins over the increment in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (we_lo_i || we_hi_i) begin
      if (we_lo_i) cnt_q[31:0]  <= wdata_i;
      if (we_hi_i) cnt_q[63:32] <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 64'd1;
    end
  end

  assign mtime_o = cnt_q;
endmodule

// File: rtl/htu_hart_slot.sv
module htu_hart_slot (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sw_we_i,
  input  logic           cmp_we_lo_i,
  input  logic           cmp_we_hi_i,
  input  logic [31:0]    wdata_i,
  input  htu_pkg::time_t mtime_i,
  output logic           sw_o,
  output htu_pkg::time_t cmp_o,
  output logic           irq_o
);
  logic           sw_q;
  htu_pkg::time_t cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      cmp_q <= '1;
    end else begin
      if (sw_we_i)     sw_q          <= wdata_i[0];
      if (cmp_we_lo_i) cmp_q[31:0]   <= wdata_i;
      if (cmp_we_hi_i) cmp_q[63:32]  <= wdata_i;
    end
  end

  assign sw_o  = sw_q;
  assign cmp_o = cmp_q;
  assign irq_o = mtime_i >= cmp_q;
endmodule

// File: rtl/htu_rdmux.sv
module htu_rdmux #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic [NUM_HARTS-1:0]       sel_sw_i,
  input  logic [NUM_HARTS-1:0]       sel_cmp_i,
  input  logic                       sel_tim_i,
  input  logic                       hi_i,
  input  logic [NUM_HARTS-1:0]       sw_i,
  input  logic [NUM_HARTS-1:0][63:0] cmp_i,
  input  htu_pkg::time_t             mtime_i,
  output logic [31:0]                rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (sel_sw_i[h])  rdata_o = rdata_o | {31'b0, sw_i[h]};
      if (sel_cmp_i[h]) rdata_o = rdata_o | (hi_i ? cmp_i[h][63:32] : cmp_i[h][31:0]);
    end
    if (sel_tim_i) rdata_o = rdata_o | (hi_i ? mtime_i[63:32] : mtime_i[31:0]);
  end
endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [15:0]          bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic                 bus_rvalid_o,
  output logic [31:0]          bus_rdata_o,
  input  logic                 tick_i,
  output logic [NUM_HARTS-1:0] sw_irq_o,
  output logic [NUM_HARTS-1:0] tmr_irq_o
);
  logic [NUM_HARTS-1:0]       sel_sw, sel_cmp, cmp_wr;
  logic                       sel_tim, sel_hi, wr, rd;
  logic                       cnt_we_lo, cnt_we_hi, cnt_wr;
  logic [NUM_HARTS-1:0][63:0] cmp_arr;
  htu_pkg::time_t             mtime;
  logic [31:0]                rd_val;

  assign wr        = bus_req_i && bus_we_i;
  assign rd        = bus_req_i && !bus_we_i;
  assign cnt_we_lo = wr && sel_tim && !sel_hi;
  assign cnt_we_hi = wr && sel_tim && sel_hi;
  assign cnt_wr    = cnt_we_lo || cnt_we_hi;

  htu_decode #(.NUM_HARTS(NUM_HARTS)) u_dec (
    .addr_i   (bus_addr_i),
    .sel_sw_o (sel_sw),
    .sel_cmp_o(sel_cmp),
    .sel_tim_o(sel_tim),
    .hi_o     (sel_hi)
  );

  htu_mtime u_mtime (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .we_lo_i(cnt_we_lo),
    .we_hi_i(cnt_we_hi),
    .wdata_i(bus_wdata_i),
    .mtime_o(mtime)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign cmp_wr[h] = wr && sel_cmp[h];
    htu_hart_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sw_we_i    (wr && sel_sw[h]),
      .cmp_we_lo_i(cmp_wr[h] && !sel_hi),
      .cmp_we_hi_i(cmp_wr[h] && sel_hi),
      .wdata_i    (bus_wdata_i),
      .mtime_i    (mtime),
      .sw_o       (sw_irq_o[h]),
      .cmp_o      (cmp_arr[h]),
      .irq_o      (tmr_irq_o[h])
    );
  end

  htu_rdmux #(.NUM_HARTS(NUM_HARTS)) u_rdmux (
    .sel_sw_i (sel_sw),
    .sel_cmp_i(sel_cmp),
    .sel_tim_i(sel_tim),
    .hi_i     (sel_hi),
    .sw_i     (sw_irq_o),
    .cmp_i    (cmp_arr),
    .mtime_i  (mtime),
    .rdata_o  (rd_val)
  );

  // load data is the value seen in the request cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= rd;
      if (rd) bus_rdata_o <= rd_val;
    end
  end
endmodule

// File: rtl/htu_chk.sv
module htu_chk #(
  parameter int unsigned NUM_HARTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_req_i,
  input logic                 bus_we_i,
  input logic                 bus_rvalid_o,
  input logic                 tick_i,
  input logic                 cnt_wr,
  input logic [63:0]          mtime,
  input logic [NUM_HARTS-1:0] cmp_wr,
  input logic [NUM_HARTS-1:0] sw_irq_o,
  input logic [NUM_HARTS-1:0] tmr_irq_o
);
  AST_RD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i) |=> bus_rvalid_o); // R9
  AST_NO_STRAY_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> !bus_rvalid_o); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr) |=> (mtime == $past(mtime) + 64'd1)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr) |=> $stable(mtime)); // R4
  AST_SW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_we_i) |=> $stable(sw_irq_o)); // R2

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_lvl
    AST_TMR_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_irq_o[h] && !cmp_wr[h] && !cnt_wr && (mtime != '1)) |=> tmr_irq_o[h]); // R7
  end
endmodule

bind hart_timer_unit htu_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_rvalid_o(bus_rvalid_o),
  .tick_i      (tick_i),
  .cnt_wr      (cnt_wr),
  .mtime       (mtime),
  .cmp_wr      (cmp_wr),
  .sw_irq_o    (sw_irq_o),
  .tmr_irq_o   (tmr_irq_o)
);

// File: tb/hart_timer_unit_tb_top.sv
module hart_timer_unit_tb_top;
  localparam int unsigned NH = 4;

  typedef struct {
    logic [31:0] data;
    bit          any;
    string       tag;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic          rvalid;
  logic [31:0]   rdata;
  logic [NH-1:0] sw_irq, tmr_irq;

  int checks = 0;
  int fails  = 0;
  exp_t exp_q[$];

  always #5 clk_i = ~clk_i;

  hart_timer_unit #(.NUM_HARTS(NH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
    .tick_i(tick), .sw_irq_o(sw_irq), .tmr_irq_o(tmr_irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic bus_wr(logic [15:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk_i);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, logic [31:0] e, string tag);
    exp_t it;
    it.data = e; it.any = 1'b0; it.tag = tag;
    exp_q.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk_i);
    req = 1'b0;
  endtask

  task automatic bus_rd_raw(logic [15:0] a, output logic [31:0] d);
    exp_t it;
    it.data = '0; it.any = 1'b1; it.tag = "R10";
    exp_q.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk_i);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected response act=%h exp=none", rdata);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        if (!it.any) chk(it.tag, {32'b0, rdata}, {32'b0, it.data});
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] h1, lo, h2;
    int tries;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1
    chk("R1 sw", {60'b0, sw_irq}, 64'h0);
    chk("R1 tmr", {60'b0, tmr_irq}, 64'h0);
    chk("R1 rvalid", {63'b0, rvalid}, 64'h0);
    bus_rd(16'hBFF8, 32'h0, "R1 cnt lo");
    bus_rd(16'hBFFC, 32'h0, "R1 cnt hi");
    bus_rd(16'h4004, 32'hFFFF_FFFF, "R1 cmp0 hi");
    bus_rd(16'h4018, 32'hFFFF_FFFF, "R1 cmp3 lo");
    // R2
    bus_wr(16'h0004, 32'h1);
    chk("R2 set h1", {60'b0, sw_irq}, 64'h2);
    chk("R9 no resp on store", {63'b0, rvalid}, 64'h0);
    bus_wr(16'h0008, 32'hFFFF_FFFF);
    chk("R2 set h2", {60'b0, sw_irq}, 64'h6);
    bus_rd(16'h0008, 32'h1, "R2 rd h2 upper zero");
    bus_wr(16'h0004, 32'h0);
    chk("R2 clr h1", {60'b0, sw_irq}, 64'h4);
    bus_rd(16'h0004, 32'h0, "R2 rd h1");
    // R3
    bus_wr(16'h4010, 32'hA5A5_0001);
    bus_wr(16'h4014, 32'h0000_1234);
    bus_rd(16'h4010, 32'hA5A5_0001, "R3 cmp2 lo");
    bus_rd(16'h4014, 32'h0000_1234, "R3 cmp2 hi");
    // R8
    bus_wr(16'h0010, 32'h1);
    chk("R8 sw beyond harts", {60'b0, sw_irq}, 64'h4);
    bus_rd(16'h0010, 32'h0, "R8 sw beyond rd");
    bus_wr(16'h0009, 32'h0);
    chk("R8 unaligned store", {60'b0, sw_irq}, 64'h4);
    bus_wr(16'h4020, 32'h0);
    bus_rd(16'h4018, 32'hFFFF_FFFF, "R8 cmp3 untouched");
    bus_rd(16'h4020, 32'h0, "R8 cmp beyond rd");
    bus_rd(16'h8000, 32'h0, "R8 gap rd");
    bus_rd(16'h0002, 32'h0, "R8 unaligned rd");
    chk("R8 tmr quiet", {60'b0, tmr_irq}, 64'h0);
    // R4 hold and R6 store vs tick
    bus_wr(16'hBFFC, 32'h5);
    idle(3);
    bus_rd(16'hBFFC, 32'h5, "R4 hold hi");
    tick = 1'b1;
    bus_wr(16'hBFF8, 32'h100);
    tick = 1'b0;
    bus_rd(16'hBFF8, 32'h100, "R6 lo store wins");
    bus_rd(16'hBFFC, 32'h5, "R6 hi kept");
    tick = 1'b1;
    bus_wr(16'hBFFC, 32'h7);
    tick = 1'b0;
    bus_rd(16'hBFF8, 32'h100, "R6 lo kept");
    bus_rd(16'hBFFC, 32'h7, "R6 hi store wins");
    // R4 and R5 carry
    bus_wr(16'hBFFC, 32'h0);
    bus_wr(16'hBFF8, 32'hFFFF_FFFE);
    tick = 1'b1;
    idle(3);
    tick = 1'b0;
    bus_rd(16'hBFF8, 32'h1, "R5 carry lo");
    bus_rd(16'hBFFC, 32'h1, "R5 carry hi");
    // R5 wrap
    bus_wr(16'hBFF8, 32'hFFFF_FFFF);
    bus_wr(16'hBFFC, 32'hFFFF_FFFF);
    tick = 1'b1;
    idle(1);
    tick = 1'b0;
    bus_rd(16'hBFF8, 32'h0, "R5 wrap lo");
    bus_rd(16'hBFFC, 32'h0, "R5 wrap hi");
    // R7
    bus_wr(16'hBFF8, 32'h10);
    bus_wr(16'h4000, 32'h12);
    bus_wr(16'h4004, 32'h0);
    chk("R7 below", {60'b0, tmr_irq}, 64'h0);
    tick = 1'b1;
    idle(1);
    tick = 1'b0;
    chk("R7 one short", {60'b0, tmr_irq}, 64'h0);
    tick = 1'b1;
    idle(1);
    tick = 1'b0;
    chk("R7 equal fires", {60'b0, tmr_irq}, 64'h1);
    tick = 1'b1;
    idle(1);
    tick = 1'b0;
    idle(4);
    chk("R7 level held", {60'b0, tmr_irq}, 64'h1);
    bus_wr(16'h4000, 32'h100);
    chk("R7 cleared by larger cmp", {60'b0, tmr_irq}, 64'h0);
    // R10 coherent split read across a carry
    bus_wr(16'hBFFC, 32'h2);
    bus_wr(16'hBFF8, 32'hFFFF_FFFE);
    tick = 1'b1;
    tries = 0;
    do begin
      bus_rd_raw(16'hBFFC, h1);
      bus_rd_raw(16'hBFF8, lo);
      bus_rd_raw(16'hBFFC, h2);
      tries++;
    end while (h1 != h2 && tries < 4);
    tick = 1'b0;
    chk("R10 retries", 64'(tries), 64'd2);
    chk("R10 value", {h1, lo}, 64'h3_0000_0002);
    idle(2);
    chk("R9 all responses seen", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule